// File: doc/BRIEF.md
# Host Register FIS Controller

This block is the host-side transport engine for register traffic on a serial storage link. A write to the shadow Command register or to the shadow Device Control register causes it to assemble an outbound host-to-device register FIS of five dwords. It streams those dwords to the link layer under a valid/ready handshake and then waits for the link's ending status. A bad ending status is reported upward as a one-cycle error pulse.

On the receive side it inspects the first dword of every frame that the link announces. A device-to-host register FIS or a set-device-bits FIS updates the shadow status and error registers once the frame ends with good status. Any other type is drained and ignored. An arriving frame takes priority over a register write that has not yet started. That write stays pending and is sent as soon as reception finishes.

Top module: `host_regfis_xport`

## Requirements
- R1: After reset, busy, tx_valid, tx_err, rx_err and irq are low, and sh_status and sh_error read 00h.
- R2: A command write produces five dwords, in this order: {feature, command, 80h, 27h}, the address dword, zero, {device control, 24'h0}, zero. tx_last is high on the fifth dword only.
- R3: A device control write produces the same five dwords, except that the flag byte (bits 15:8 of the first dword) is 00h, so its bit 7 (the C bit) is clear.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R5: After the last dword the block raises no tx_valid and waits for tx_done. tx_done with tx_ok low gives a one-cycle tx_err pulse in the cycle after, and tx_ok high gives none.
- R6: busy rises in the cycle after a register write and stays high until the ending status of the last pending FIS. A write made while busy is kept and sent later. When both kinds are pending, the control FIS goes first.
- R7: A frame start (rx_valid with rx_sof) seen while idle is handled before any pending transmission. No dword is offered until that frame has ended.
- R8: Type 34h in byte 0 of the first dword loads sh_status from byte 2 and sh_error from byte 3 when rx_end arrives with rx_good. The class is fixed by the first dword alone.
- R9: Type A1h replaces status bits 6:4 and 2:0 and keeps bits 7 and 3. It replaces the error byte. The update is applied only on a good end.
- R10: For either recognised type, irq pulses for one cycle after a good end exactly when bit 14 (byte 1, bit 6) of the first dword was set. A bad end leaves both shadow registers unchanged and pulses rx_err instead.
- R11: Any other type code is ignored: no shadow change, no irq, no rx_err, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Pulse: shadow Command register written |
| ctl_wr | input | 1 | Pulse: shadow Device Control register written |
| sh_cmd | input | 8 | Shadow command byte |
| sh_feat | input | 8 | Shadow feature byte |
| sh_ctl | input | 8 | Shadow device control byte |
| sh_addr | input | 32 | Shadow device/address dword |
| tx_valid | output | 1 | Outbound dword valid |
| tx_data | output | 32 | Outbound dword |
| tx_last | output | 1 | Final dword of the FIS |
| tx_ready | input | 1 | Link accepts the dword |
| tx_done | input | 1 | Link ending status strobe |
| tx_ok | input | 1 | Ending status good |
| tx_err | output | 1 | Pulse: transmission failed |
| busy | output | 1 | Register FIS pending or in flight |
| rx_valid | input | 1 | Inbound dword valid |
| rx_sof | input | 1 | Inbound dword is the first of a frame |
| rx_data | input | 32 | Inbound dword |
| rx_end | input | 1 | Inbound frame ending status strobe |
| rx_good | input | 1 | Inbound frame ended without error |
| sh_status | output | 8 | Shadow status register |
| sh_error | output | 8 | Shadow error register |
| irq | output | 1 | Pulse: interrupt requested by received FIS |
| rx_err | output | 1 | Pulse: recognised FIS ended with error |

## Verification
The assertions cover the local invariants on every cycle. Offered dwords hold steady under back-pressure, tx_last only appears with tx_valid, and busy covers every offered dword. A frame start in idle blocks a transmission start. Shadow changes, irq and tx_err each follow their matching good or bad ending strobe. The bench scenarios show what those per-cycle checks cannot. They sweep dword contents across shadow values, check status merging over sequences of set-device-bits frames, and cover the ordering of preempted, latched and doubly pending writes. They also show that unrecognised types leave all state untouched.

// File: rtl/htr_pkg.sv
`timescale 1ns/1ps
package htr_pkg;
    localparam int unsigned DWORD_W = 32;
    localparam logic [7:0] TYPE_H2D_REG = 8'h27;
    localparam logic [7:0] TYPE_D2H_REG = 8'h34;
    localparam logic [7:0] TYPE_SDB     = 8'hA1;
    localparam logic [7:0] IRQ_FLAG_MASK = 8'h40;
    localparam logic [7:0] SDB_KEEP_MASK = 8'h88;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_SEND,
        ST_TX_WAIT,
        ST_RX_REG,
        ST_RX_SDB,
        ST_RX_SKIP
    } st_e;

    typedef enum logic [1:0] {
        CLS_REG,
        CLS_SDB,
        CLS_OTHER
    } rx_cls_e;
endpackage

// File: rtl/htr_tx_builder.sv
`timescale 1ns/1ps
module htr_tx_builder
    import htr_pkg::*;
#(
    parameter int unsigned NDW = 5,
    localparam int unsigned IW = (NDW > 1) ? $clog2(NDW) : 1
) (
    input  logic [IW-1:0]      idx,
    input  logic               is_cmd,
    input  logic [7:0]         cmd,
    input  logic [7:0]         feat,
    input  logic [7:0]         ctl,
    input  logic [DWORD_W-1:0] addr,
    output logic [DWORD_W-1:0] dword
);
    logic [7:0] flags;
    assign flags = {is_cmd, 7'b0};

    always_comb begin
        case (idx)
            IW'(0):  dword = {feat, cmd, flags, TYPE_H2D_REG};
            IW'(1):  dword = addr;
            IW'(3):  dword = {ctl, 24'h0};
            default: dword = '0;
        endcase
    end
endmodule

// File: rtl/htr_rx_classify.sv
`timescale 1ns/1ps
module htr_rx_classify
    import htr_pkg::*;
(
    input  logic [7:0] type_byte,
    output rx_cls_e    cls
);
    always_comb begin
        if (type_byte == TYPE_D2H_REG)  cls = CLS_REG;
        else if (type_byte == TYPE_SDB) cls = CLS_SDB;
        else                            cls = CLS_OTHER;
    end
endmodule

// File: rtl/htr_status_merge.sv
`timescale 1ns/1ps
module htr_status_merge #(
    parameter logic [7:0] KEEP_MASK = 8'h88
) (
    input  logic [7:0] cur,
    input  logic [7:0] upd,
    output logic [7:0] merged
);
    assign merged = (cur & KEEP_MASK) | (upd & ~KEEP_MASK);
endmodule

// File: rtl/host_regfis_xport.sv
`timescale 1ns/1ps
module host_regfis_xport
    import htr_pkg::*;
#(
    parameter int unsigned NDW = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        ctl_wr,
    input  logic [7:0]  sh_cmd,
    input  logic [7:0]  sh_feat,
    input  logic [7:0]  sh_ctl,
    input  logic [31:0] sh_addr,
    output logic        tx_valid,
    output logic [31:0] tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        tx_done,
    input  logic        tx_ok,
    output logic        tx_err,
    output logic        busy,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [31:0] rx_data,
    input  logic        rx_end,
    input  logic        rx_good,
    output logic [7:0]  sh_status,
    output logic [7:0]  sh_error,
    output logic        irq,
    output logic        rx_err
);
    localparam int unsigned IW = (NDW > 1) ? $clog2(NDW) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NDW - 1);

    typedef struct packed {
        st_e          st;
        logic [IW-1:0] idx;
        logic         is_cmd;
        logic         cmd_p;
        logic         ctl_p;
        logic [7:0]   snap_cmd;
        logic [7:0]   snap_feat;
        logic [7:0]   snap_ctl;
        logic [31:0]  snap_addr;
        logic [7:0]   hold_stat;
        logic [7:0]   hold_err;
        logic         hold_irq;
        logic [7:0]   stat;
        logic [7:0]   err;
        logic         irq;
        logic         tx_err;
        logic         rx_err;
    } regs_t;

    regs_t   q, d;
    rx_cls_e rx_cls;
    logic [7:0]  sdb_stat;
    logic [31:0] built;

    htr_rx_classify u_cls (
        .type_byte (rx_data[7:0]),
        .cls       (rx_cls)
    );

    htr_status_merge #(.KEEP_MASK(SDB_KEEP_MASK)) u_merge (
        .cur    (q.stat),
        .upd    (q.hold_stat),
        .merged (sdb_stat)
    );

    htr_tx_builder #(.NDW(NDW)) u_build (
        .idx    (q.idx),
        .is_cmd (q.is_cmd),
        .cmd    (q.snap_cmd),
        .feat   (q.snap_feat),
        .ctl    (q.snap_ctl),
        .addr   (q.snap_addr),
        .dword  (built)
    );

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        d.tx_err = 1'b0;
        d.rx_err = 1'b0;
        if (cmd_wr) d.cmd_p = 1'b1;
        if (ctl_wr) d.ctl_p = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (rx_valid && rx_sof) begin
                    d.hold_stat = rx_data[23:16];
                    d.hold_err  = rx_data[31:24];
                    d.hold_irq  = |(rx_data[15:8] & IRQ_FLAG_MASK);
                    case (rx_cls)
                        CLS_REG: d.st = ST_RX_REG;
                        CLS_SDB: d.st = ST_RX_SDB;
                        default: d.st = ST_RX_SKIP;
                    endcase
                end else if (q.ctl_p || q.cmd_p) begin
                    d.st        = ST_TX_SEND;
                    d.idx       = '0;
                    d.is_cmd    = !q.ctl_p;
                    d.snap_cmd  = sh_cmd;
                    d.snap_feat = sh_feat;
                    d.snap_ctl  = sh_ctl;
                    d.snap_addr = sh_addr;
                    if (q.ctl_p) d.ctl_p = ctl_wr;
                    else         d.cmd_p = cmd_wr;
                end
            end
            ST_TX_SEND: begin
                if (tx_ready) begin
                    if (q.idx == LAST_IDX) d.st  = ST_TX_WAIT;
                    else                   d.idx = q.idx + IW'(1);
                end
            end
            ST_TX_WAIT: begin
                if (tx_done) begin
                    d.tx_err = !tx_ok;
                    d.st     = ST_IDLE;
                end
            end
            ST_RX_REG, ST_RX_SDB: begin
                if (rx_end) begin
                    if (rx_good) begin
                        d.stat = (q.st == ST_RX_SDB) ? sdb_stat : q.hold_stat;
                        d.err  = q.hold_err;
                        d.irq  = q.hold_irq;
                    end else begin
                        d.rx_err = 1'b1;
                    end
                    d.st = ST_IDLE;
                end
            end
            ST_RX_SKIP: begin
                if (rx_end) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tx_valid  = (q.st == ST_TX_SEND);
    assign tx_last   = tx_valid && (q.idx == LAST_IDX);
    assign tx_data   = built;
    assign busy      = q.cmd_p || q.ctl_p || (q.st == ST_TX_SEND) || (q.st == ST_TX_WAIT);
    assign tx_err    = q.tx_err;
    assign rx_err    = q.rx_err;
    assign irq       = q.irq;
    assign sh_status = q.stat;
    assign sh_error  = q.err;
endmodule

// File: rtl/htr_checker.sv
`timescale 1ns/1ps
module htr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_last,
    input logic [31:0] tx_data,
    input logic        tx_done,
    input logic        tx_ok,
    input logic        tx_err,
    input logic        busy,
    input logic        rx_valid,
    input logic        rx_sof,
    input logic        rx_end,
    input logic        rx_good,
    input logic        irq,
    input logic [7:0]  sh_status
);
    a_r2_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r5_err_follows_bad_end: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> $past(tx_done && !tx_ok));

    a_r6_busy_covers_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    a_r7_rx_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !tx_valid) |=> !tx_valid);

    a_r8_status_after_good_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_status) |-> $past(rx_end && rx_good));

    a_r10_irq_after_good_end: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_end && rx_good));
endmodule

bind host_regfis_xport htr_checker u_htr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last),
    .tx_data   (tx_data),
    .tx_done   (tx_done),
    .tx_ok     (tx_ok),
    .tx_err    (tx_err),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .rx_end    (rx_end),
    .rx_good   (rx_good),
    .irq       (irq),
    .sh_status (sh_status)
);

// File: tb/host_regfis_xport_bench.sv
`timescale 1ns/1ps
module host_regfis_xport_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cmd_wr = 0, ctl_wr = 0;
    logic [7:0]  sh_cmd = 0, sh_feat = 0, sh_ctl = 0;
    logic [31:0] sh_addr = 0;
    logic        tx_ready = 0, tx_done = 0, tx_ok = 0;
    logic        rx_valid = 0, rx_sof = 0, rx_end = 0, rx_good = 0;
    logic [31:0] rx_data = 0;
    logic        tx_valid, tx_last, tx_err, busy, irq, rx_err;
    logic [31:0] tx_data;
    logic [7:0]  sh_status, sh_error;

    host_regfis_xport u_host_regfis_xport (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .ctl_wr(ctl_wr),
        .sh_cmd(sh_cmd), .sh_feat(sh_feat), .sh_ctl(sh_ctl), .sh_addr(sh_addr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_done(tx_done), .tx_ok(tx_ok), .tx_err(tx_err), .busy(busy),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data), .rx_end(rx_end),
        .rx_good(rx_good), .sh_status(sh_status), .sh_error(sh_error), .irq(irq),
        .rx_err(rx_err)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_stat = 8'h00;
    logic [7:0] m_err  = 8'h00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_dw(input int k, input logic c);
        case (k)
            0: return {sh_feat, sh_cmd, c ? 8'h80 : 8'h00, 8'h27};
            1: return sh_addr;
            3: return {sh_ctl, 24'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic send_fis(input logic c, input logic ok, input logic stall, input logic more);
        int w = 0;
        while (!tx_valid && w < 40) begin @(negedge clk); w++; end
        chk("R6 transmission starts", tx_valid, 1);
        for (int k = 0; k < 5; k++) begin
            chk(c ? "R2 command dword" : "R3 control dword", tx_data, exp_dw(k, c));
            chk("R2 last marker", tx_last, (k == 4));
            if (stall && k == 2) begin
                tx_ready = 0;
                @(negedge clk);
                chk("R4 valid held", tx_valid, 1);
                chk("R4 data held", tx_data, exp_dw(k, c));
                @(negedge clk);
                chk("R4 data held 2", tx_data, exp_dw(k, c));
            end
            tx_ready = 1;
            @(negedge clk);
        end
        tx_ready = 0;
        chk("R5 no dword while waiting", tx_valid, 0);
        chk("R5 busy while waiting", busy, 1);
        tx_done = 1; tx_ok = ok;
        @(negedge clk);
        tx_done = 0; tx_ok = 0;
        chk("R5 error pulse", tx_err, !ok);
        chk("R6 busy after status", busy, more);
        @(negedge clk);
        chk("R5 error one cycle", tx_err, 0);
    endtask

    task automatic rx_fis(input logic [7:0] typ, input logic [7:0] flg, input logic [7:0] st,
                          input logic [7:0] er, input logic good);
        rx_valid = 1; rx_sof = 1; rx_data = {er, st, flg, typ};
        @(negedge clk);
        rx_sof = 0; rx_data = 32'hA1A1_A134;
        @(negedge clk);
        rx_valid = 0; rx_end = 1; rx_good = good;
        @(negedge clk);
        rx_end = 0; rx_good = 0;
    endtask

    task automatic pulse_cmd();
        cmd_wr = 1; @(negedge clk); cmd_wr = 0;
    endtask

    task automatic pulse_ctl();
        ctl_wr = 1; @(negedge clk); ctl_wr = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 tx_err", tx_err, 0);
        chk("R1 rx_err", rx_err, 0);
        chk("R1 irq", irq, 0);
        chk("R1 status", sh_status, 0);
        chk("R1 error", sh_error, 0);

        // R2 R3 R4 R5: sweep of shadow contents, stalls and ending status
        for (int i = 0; i < 4; i++) begin
            sh_cmd  = 8'h20 + 8'(i * 8'h15);
            sh_feat = 8'(i * 3);
            sh_addr = 32'hE000_0000 | (i * 32'h0101_0101);
            sh_ctl  = i[0] ? 8'h04 : 8'h08;
            chk("R6 idle before write", busy, 0);
            pulse_cmd();
            chk("R6 busy after command write", busy, 1);
            send_fis(1'b1, i != 2, i == 1, 1'b0);
            pulse_ctl();
            chk("R6 busy after control write", busy, 1);
            send_fis(1'b0, 1'b1, i == 3, 1'b0);
        end

        // R6 both pending: control first
        cmd_wr = 1; ctl_wr = 1; @(negedge clk); cmd_wr = 0; ctl_wr = 0;
        send_fis(1'b0, 1'b1, 1'b0, 1'b1);
        send_fis(1'b1, 1'b1, 1'b0, 1'b0);

        // R6 write during busy is latched
        pulse_cmd();
        @(negedge clk);
        pulse_ctl();
        send_fis(1'b1, 1'b1, 1'b0, 1'b1);
        send_fis(1'b0, 1'b1, 1'b0, 1'b0);

        // R7 preemption by an arriving register FIS
        cmd_wr = 1; rx_valid = 1; rx_sof = 1; rx_data = {8'h00, 8'h50, 8'h40, 8'h34};
        @(negedge clk);
        cmd_wr = 0; rx_sof = 0; rx_data = 32'h0;
        chk("R7 no dword during receive", tx_valid, 0);
        chk("R7 write pending", busy, 1);
        @(negedge clk);
        rx_valid = 0; rx_end = 1; rx_good = 1;
        chk("R7 no dword before end", tx_valid, 0);
        @(negedge clk);
        rx_end = 0; rx_good = 0;
        m_stat = 8'h50; m_err = 8'h00;
        chk("R8 status after preempting FIS", sh_status, m_stat);
        chk("R10 irq after preempting FIS", irq, 1);
        send_fis(1'b1, 1'b1, 1'b0, 1'b0);

        // R8 R10 register FIS sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] st, er, fl;
            logic good;
            st = 8'h41 + 8'(i * 8'h13);
            er = ~st;
            fl = i[0] ? 8'h40 : 8'hBF;
            good = (i != 5);
            rx_fis(8'h34, fl, st, er, good);
            if (good) begin m_stat = st; m_err = er; end
            chk("R8 register status", sh_status, m_stat);
            chk("R8 register error", sh_error, m_err);
            chk("R10 register irq", irq, good && i[0]);
            chk("R10 register rx_err", rx_err, !good);
            @(negedge clk);
            chk("R10 irq one cycle", irq, 0);
        end

        // R9 R10 set-device-bits sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] st, er, fl;
            logic good;
            st = 8'(i * 8'h11) ^ 8'hC3;
            er = 8'(i * 7);
            fl = i[1] ? 8'h40 : 8'h00;
            good = (i != 9);
            rx_fis(8'hA1, fl, st, er, good);
            if (good) begin
                m_stat = (m_stat & 8'h88) | (st & 8'h77);
                m_err  = er;
            end
            chk("R9 merged status", sh_status, m_stat);
            chk("R9 error", sh_error, m_err);
            chk("R10 sdb irq", irq, good && i[1]);
            chk("R10 sdb rx_err", rx_err, !good);
            @(negedge clk);
        end

        // R11 unrecognised types
        for (int i = 0; i < 4; i++) begin
            logic [7:0] t;
            t = (i == 0) ? 8'h46 : (i == 1) ? 8'h39 : (i == 2) ? 8'h5F : 8'h00;
            rx_fis(t, 8'h40, 8'hFF, 8'hFF, 1'b1);
            chk("R11 status untouched", sh_status, m_stat);
            chk("R11 error untouched", sh_error, m_err);
            chk("R11 no irq", irq, 0);
            chk("R11 no rx_err", rx_err, 0);
            chk("R11 idle", busy, 0);
        end
        pulse_cmd();
        send_fis(1'b1, 1'b1, 1'b0, 1'b0);

        finish_run();
    end
endmodule